// File: doc/BRIEF.md
# MSI Interrupt Request Handler

This block lives on the application side of a PCI Express endpoint. It collects interrupt events from up to 32 sources and turns them into message-signalled interrupt requests for the link core. Each source has a sticky pending bit and an enable. The block picks one pending, enabled source at a time in rotating order. It folds the source index onto the number of message vectors the host actually allocated, and presents a request with a message number and a traffic class. It then waits for the link core's acknowledge.

The link core emits a message for every request it sees and does not look at the configuration state. This block therefore never starts a request unless both the message-interrupt enable and the bus-master enable are set. A parameter selects per-source enables or a single global enable. The legacy-interrupt disable bit from the command register is accepted as an input and reported back as a registered status.

Top module: `msi_irq_handler`

## Requirements
- R1: After a synchronous active-low reset, `msi_req` is low, `intx_off` is low and no source is pending.
- R2: A request is raised only when `cfg_msi_en` and `cfg_bme` are both 1. An event on an enabled source, with both bits set and no request outstanding, raises `msi_req` at the second rising edge after the event was sampled.
- R3: `cfg_mme` = n allocates 2^min(n,5) vectors, and `msi_num` equals the source index with bits n and above forced to 0.
- R4: With `PER_SRC_EN`=1, a source whose bit in `src_en` is 0 never causes a request. Its pending bit is kept, and it is issued once the enable returns to 1.
- R5: With `PER_SRC_EN`=0, `glb_en` gates all sources and `src_en` is ignored.
- R6: A source with `src_is_sys[i]`=1 is sent with traffic class 0. Any other source uses `src_tc[3*i+2:3*i]`.
- R7: Once high, `msi_req` stays high, with `msi_num` and `msi_tc` unchanged, until `msi_ack` is sampled high.
- R8: `msi_req` falls at the edge that samples `msi_ack` high, and each grant produces exactly one request.
- R9: A source's pending bit clears only on the acknowledge for its grant. An event on the same source in the acknowledge cycle, or an event on another source while a request is outstanding, leads to a later request.
- R10: Among several pending, enabled sources, the next grant goes to the first one found searching upward, with wrap, from the index after the last granted source. After reset the search starts at index 0.
- R11: `intx_off` follows `cfg_intx_disable` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_event | input | NUM_SRC | Per-source event pulses |
| src_en | input | NUM_SRC | Per-source enables (per-source mode) |
| glb_en | input | 1 | Global enable (global mode) |
| src_is_sys | input | NUM_SRC | Source is a system/hot-plug/power event (class 0) |
| src_tc | input | NUM_SRC*TC_W | Per-source traffic class, 3 bits per source |
| cfg_msi_en | input | 1 | Message-interrupt enable from configuration |
| cfg_bme | input | 1 | Bus-master enable from configuration |
| cfg_mme | input | 3 | Allocated vector count, log2 encoded |
| cfg_intx_disable | input | 1 | Command-register legacy interrupt disable bit |
| intx_off | output | 1 | Registered legacy-off status |
| msi_req | output | 1 | Request to link core |
| msi_num | output | 5 | Message number |
| msi_tc | output | TC_W | Traffic class |
| msi_ack | input | 1 | Acknowledge from link core |

## Verification
Every source index is sent under every allocation size from 1 to 32 vectors. This separates correct masking of the upper bits from masking that is off by one bit, and per-source traffic class selection from the system-class override. Events held back by either configuration bit, or by a per-source or global enable, show whether gating drops or keeps the pending state. A burst of four sources released at once tells true rotation from fixed priority. Events placed in the acknowledge cycle, and on another source while a request is outstanding, tell a sticky pending bit from one that is lost.

// File: rtl/msi_pkg.sv
// Package: shared types and helpers for the message-interrupt handler.
// Assumes a 5-bit message number and a 3-bit log2 vector-count encoding.
package msi_pkg;
    localparam int MSG_W = 5;
    localparam int MME_W = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } msi_state_e;

    // Bit mask that keeps the low min(mme,5) bits of a message number.
    function automatic logic [MSG_W-1:0] alloc_mask(input logic [MME_W-1:0] mme);
        logic [MSG_W-1:0] m;
        for (int b = 0; b < MSG_W; b++) begin
            m[b] = (b < int'(mme));
        end
        return m;
    endfunction
endpackage

// File: rtl/msi_pending.sv
// Module: sticky pending bits, one per source.
// Set by an event; cleared only when the granted index is acknowledged.
// A set in the same cycle as a clear wins, so no event is lost.
module msi_pending #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // Track one source's pending state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (set_vec[g]) begin
                pend[g] <= 1'b1;
            end else if (clr_en && (clr_idx == IDX_W'(g))) begin
                pend[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/msi_rr_arb.sv
// Module: rotating-priority picker.
// Finds the first asserted bit of cand, searching upward with wrap from
// the index after last_idx. Purely combinational.
module msi_rr_arb #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] cand,
    input  logic [IDX_W-1:0]   last_idx,
    output logic               found,
    output logic [IDX_W-1:0]   pick
);
    // Scan all positions starting after the last grant.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            int p;
            p = int'(last_idx) + k;
            if (p >= NUM_SRC) p = p - NUM_SRC;
            if (!found && cand[p]) begin
                found = 1'b1;
                pick  = IDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/msi_vec_map.sv
// Module: folds a source index onto the allocated message range and picks
// its traffic class. System-class sources always use class 0.
module msi_vec_map #(
    parameter int NUM_SRC = 32,
    parameter int TC_W = 3,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [2:0]              mme,
    input  logic [NUM_SRC-1:0]      is_sys,
    input  logic [NUM_SRC*TC_W-1:0] tc_all,
    output logic [4:0]              num,
    output logic [TC_W-1:0]         tc
);
    import msi_pkg::*;

    // Mask the index to the allocated vector count.
    always_comb begin
        num = MSG_W'(idx) & alloc_mask(mme);
    end

    // Choose the traffic class for the selected source.
    always_comb begin
        if (is_sys[idx]) tc = '0;
        else             tc = tc_all[int'(idx)*TC_W +: TC_W];
    end
endmodule

// File: rtl/msi_irq_handler.sv
// Module: top of the message-interrupt request handler.
// Gates requests on message-interrupt and bus-master enables, arbitrates
// pending sources in rotating order, holds one request until acknowledged.
// Assumes NUM_SRC <= 32 and an acknowledge that is a level sampled per edge.
module msi_irq_handler #(
    parameter int NUM_SRC = 32,
    parameter int TC_W = 3,
    parameter bit PER_SRC_EN = 1'b1,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_event,
    input  logic [NUM_SRC-1:0]      src_en,
    input  logic                    glb_en,
    input  logic [NUM_SRC-1:0]      src_is_sys,
    input  logic [NUM_SRC*TC_W-1:0] src_tc,
    input  logic                    cfg_msi_en,
    input  logic                    cfg_bme,
    input  logic [2:0]              cfg_mme,
    input  logic                    cfg_intx_disable,
    output logic                    intx_off,
    output logic                    msi_req,
    output logic [4:0]              msi_num,
    output logic [TC_W-1:0]         msi_tc,
    input  logic                    msi_ack
);
    import msi_pkg::*;

    msi_state_e         state_q;
    logic [IDX_W-1:0]   grant_q;
    logic [IDX_W-1:0]   last_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] eff_en;
    logic [NUM_SRC-1:0] cand;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic [4:0]         map_num;
    logic [TC_W-1:0]    map_tc;
    logic               ack_hit;
    logic               may_issue;

    if (PER_SRC_EN) begin : g_per_src
        // Per-source enables.
        always_comb eff_en = src_en;
    end else begin : g_global
        // One global enable for every source.
        always_comb eff_en = {NUM_SRC{glb_en}};
    end

    // Acknowledge of the outstanding grant.
    always_comb ack_hit = (state_q == ST_WAIT) && msi_ack;

    msi_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_event),
        .clr_en  (ack_hit),
        .clr_idx (grant_q),
        .pend    (pend)
    );

    // Candidates are pending and enabled sources.
    always_comb cand = pend & eff_en;

    msi_rr_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .cand     (cand),
        .last_idx (last_q),
        .found    (found),
        .pick     (pick)
    );

    msi_vec_map #(.NUM_SRC(NUM_SRC), .TC_W(TC_W)) u_map (
        .idx    (pick),
        .mme    (cfg_mme),
        .is_sys (src_is_sys),
        .tc_all (src_tc),
        .num    (map_num),
        .tc     (map_tc)
    );

    // Issue is allowed only in idle with both configuration enables set.
    always_comb may_issue = (state_q == ST_IDLE) && cfg_msi_en && cfg_bme && found;

    // Request handshake state and held request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msi_req <= 1'b0;
            msi_num <= '0;
            msi_tc  <= '0;
            grant_q <= '0;
            last_q  <= IDX_W'(NUM_SRC - 1);
        end else if (may_issue) begin
            state_q <= ST_WAIT;
            msi_req <= 1'b1;
            msi_num <= map_num;
            msi_tc  <= map_tc;
            grant_q <= pick;
            last_q  <= pick;
        end else if (ack_hit) begin
            state_q <= ST_IDLE;
            msi_req <= 1'b0;
        end
    end

    // Registered legacy-interrupt-off status.
    always_ff @(posedge clk) begin
        if (!rst_n) intx_off <= 1'b0;
        else        intx_off <= cfg_intx_disable;
    end
endmodule

// File: rtl/msi_irq_checker.sv
// Module: protocol checker for msi_irq_handler, attached by bind.
module msi_irq_checker #(
    parameter int TC_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_msi_en,
    input logic            cfg_bme,
    input logic [2:0]      cfg_mme,
    input logic            msi_req,
    input logic            msi_ack,
    input logic [4:0]      msi_num,
    input logic [TC_W-1:0] msi_tc
);
    import msi_pkg::*;

    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !msi_req);

    a_r2_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(cfg_msi_en && cfg_bme));

    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> ((msi_num & ~alloc_mask($past(cfg_mme))) == 5'd0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !msi_ack) |=> msi_req);

    a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !msi_ack) |=> ($stable(msi_num) && $stable(msi_tc)));

    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && msi_ack) |=> !msi_req);
endmodule

bind msi_irq_handler msi_irq_checker #(.TC_W(TC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_msi_en (cfg_msi_en),
    .cfg_bme    (cfg_bme),
    .cfg_mme    (cfg_mme),
    .msi_req    (msi_req),
    .msi_ack    (msi_ack),
    .msi_num    (msi_num),
    .msi_tc     (msi_tc)
);

// File: tb/msi_irq_handler_test.sv
module msi_irq_handler_test;
    localparam int N  = 32;
    localparam int GN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]   src_event = '0;
    logic [N-1:0]   src_en = '1;
    logic [N-1:0]   src_is_sys = '0;
    logic [N*3-1:0] src_tc = '0;
    logic           cfg_msi_en = 1'b0, cfg_bme = 1'b0, cfg_intx_disable = 1'b0;
    logic [2:0]     cfg_mme = 3'd5;
    logic           intx_off, msi_req, msi_ack = 1'b0;
    logic [4:0]     msi_num;
    logic [2:0]     msi_tc;

    msi_irq_handler #(.NUM_SRC(N), .TC_W(3), .PER_SRC_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .src_event(src_event), .src_en(src_en),
        .glb_en(1'b0), .src_is_sys(src_is_sys), .src_tc(src_tc),
        .cfg_msi_en(cfg_msi_en), .cfg_bme(cfg_bme), .cfg_mme(cfg_mme),
        .cfg_intx_disable(cfg_intx_disable), .intx_off(intx_off),
        .msi_req(msi_req), .msi_num(msi_num), .msi_tc(msi_tc), .msi_ack(msi_ack)
    );

    logic [GN-1:0] g_event = '0;
    logic          g_glb_en = 1'b0, g_ack = 1'b0;
    logic          g_intx, g_req;
    logic [4:0]    g_num;
    logic [2:0]    g_tc;

    msi_irq_handler #(.NUM_SRC(GN), .TC_W(3), .PER_SRC_EN(1'b0)) uut_glb (
        .clk(clk), .rst_n(rst_n), .src_event(g_event), .src_en('0),
        .glb_en(g_glb_en), .src_is_sys('0), .src_tc('0),
        .cfg_msi_en(1'b1), .cfg_bme(1'b1), .cfg_mme(3'd3),
        .cfg_intx_disable(1'b0), .intx_off(g_intx),
        .msi_req(g_req), .msi_num(g_num), .msi_tc(g_tc), .msi_ack(g_ack)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int i);
        src_event[i] = 1'b1;
        @(negedge clk);
        src_event[i] = 1'b0;
    endtask

    task automatic wait_req();
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (msi_req) break;
        end
    endtask

    task automatic do_ack();
        msi_ack = 1'b1;
        @(negedge clk);
        msi_ack = 1'b0;
        chk(!msi_req, "R8 drop after ack", msi_req, 0);
    endtask

    task automatic expect_num(input string tag, input int exp);
        wait_req();
        chk(msi_req && msi_num == 5'(exp), tag, msi_num, exp);
    endtask

    function automatic int exp_tc(input int i);
        return (i % 7 == 0) ? 0 : (i * 5 + 1) % 8;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            src_tc[i*3 +: 3] = 3'((i * 5 + 1) % 8);
            src_is_sys[i] = (i % 7 == 0);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!msi_req && !intx_off && !g_req, "R1 reset idle", msi_req, 0);

        // R11 legacy-off status
        cfg_intx_disable = 1'b1;
        @(negedge clk);
        chk(intx_off == 1'b1, "R11 intx_off set", intx_off, 1);
        cfg_intx_disable = 1'b0;
        @(negedge clk);
        chk(intx_off == 1'b0, "R11 intx_off clear", intx_off, 0);

        // R2 gating on enable bits
        cfg_msi_en = 1'b0; cfg_bme = 1'b1;
        pulse(5);
        repeat (4) @(negedge clk);
        chk(!msi_req, "R2 blocked by msi_en", msi_req, 0);
        cfg_msi_en = 1'b1; cfg_bme = 1'b0;
        repeat (4) @(negedge clk);
        chk(!msi_req, "R2 blocked by bme", msi_req, 0);
        cfg_bme = 1'b1;
        @(negedge clk);
        chk(msi_req && msi_num == 5'd5, "R2 issued when enabled", msi_num, 5);
        do_ack();
        // R2 latency: req after exactly two edges
        pulse(2);
        chk(!msi_req, "R2 not yet one edge", msi_req, 0);
        @(negedge clk);
        chk(msi_req && msi_num == 5'd2, "R2 two-edge latency", msi_num, 2);
        do_ack();

        // R3 / R6 sweep over every allocation and source
        for (int m = 0; m <= 5; m++) begin
            cfg_mme = 3'(m);
            for (int i = 0; i < N; i++) begin
                int en;
                en = i & ((1 << m) - 1);
                pulse(i);
                wait_req();
                chk(msi_req && msi_num == 5'(en), "R3 folded number", msi_num, en);
                chk(msi_tc == 3'(exp_tc(i)), "R6 traffic class", msi_tc, exp_tc(i));
                do_ack();
            end
        end
        cfg_mme = 3'd7;
        pulse(29);
        expect_num("R3 mme above five", 29);
        do_ack();
        cfg_mme = 3'd5;

        // R4 per-source enable retained pending
        src_en[9] = 1'b0;
        pulse(9);
        repeat (5) @(negedge clk);
        chk(!msi_req, "R4 disabled source silent", msi_req, 0);
        src_en[9] = 1'b1;
        expect_num("R4 issued on re-enable", 9);
        do_ack();
        repeat (4) @(negedge clk);
        chk(!msi_req, "R8 single request per grant", msi_req, 0);

        // R7 hold and stability without ack
        pulse(4);
        wait_req();
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            chk(msi_req && msi_num == 5'd4 && msi_tc == 3'(exp_tc(4)), "R7 held stable", msi_num, 4);
        end
        do_ack();

        // R9 event in the ack cycle and on another source while outstanding
        pulse(6);
        wait_req();
        pulse(8);
        chk(msi_req && msi_num == 5'd6, "R9 first still outstanding", msi_num, 6);
        msi_ack = 1'b1; src_event[6] = 1'b1;
        @(negedge clk);
        msi_ack = 1'b0; src_event[6] = 1'b0;
        chk(!msi_req, "R8 drop with event", msi_req, 0);
        expect_num("R9 other source kept", 8);
        do_ack();
        expect_num("R9 ack-cycle event kept", 6);
        do_ack();

        // R10 rotation after last grant
        pulse(10);
        expect_num("R10 seed grant", 10);
        do_ack();
        cfg_msi_en = 1'b0;
        src_event[3] = 1'b1; src_event[7] = 1'b1; src_event[20] = 1'b1; src_event[12] = 1'b1;
        @(negedge clk);
        src_event = '0;
        cfg_msi_en = 1'b1;
        expect_num("R10 order 1", 12);
        do_ack();
        expect_num("R10 order 2", 20);
        do_ack();
        expect_num("R10 order 3 wrap", 3);
        do_ack();
        expect_num("R10 order 4", 7);
        do_ack();

        // R5 global-enable variant
        g_event[5] = 1'b1;
        @(negedge clk);
        g_event[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk(!g_req, "R5 global enable off", g_req, 0);
        g_glb_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(g_req && g_num == 5'd5, "R5 global enable on", g_num, 5);
        g_ack = 1'b1;
        @(negedge clk);
        g_ack = 1'b0;
        chk(!g_req, "R8 global drop", g_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule